// File: doc/BRIEF.md
# Internal Control Register Bank

This block holds the processor's internal 64-bit control registers behind one indexed read port and one indexed write port. Each index has a fixed access rule. A register can take the whole word, or keep only the bits of a fixed mask. It can return to zero on any write, or it can be read-only, write-only or unassigned. An access that breaks its rule raises an error flag on the port that made it.

The bank also keeps a free-running 32-bit cycle counter. That counter supplies the low half of the cycle-count register when that register is read. A write to a write-only command index leaves the bank as a one-cycle strobe. The unit that acts on the command is outside this block.

The pipeline drives a mis-speculation flag with each write. While that flag is high the write is dropped completely.

Top module: `ctl_reg_bank`

## Requirements
- R1: On reset (synchronous, active-low `rstN`) every register reads zero, with three exceptions. Index 24 (PAL base) reads the `PAL_BASE` parameter (default 0x4000). Index 28 (machine control) reads 0x6. Index 16 (scratch) reads `cpuId` zero-extended.
- R2: Indices 0 to 28 accept all 64 bits on a write. Reads are combinational. A written value appears on `rdData` from the cycle after the write's clock edge.
- R3: A read of index 29 returns its stored bits 63:32 above the low 32 bits of a cycle counter. The counter is 0 during reset and adds 1 on every clock edge after reset. A write to index 29 stores bits 63:32.
- R4: A write to index 30 (exception address) stores the data with bit 1 forced to zero.
- R5: Indices 31 and 32 keep only bits 3:0 on a write. Indices 33 and 34 keep only mask 0x18.
- R6: The write masks are:
  - index 35: 0xFFFFFF0300
  - indices 36 and 37: 0xFFFFFFFFC0000000
  - index 38: 0x1FFB
  - indices 39 and 40: 0x3F
- R7: A write to index 41 or 42 leaves that register at zero, whatever the write data.
- R8: Indices 43 to 47 are read-only and read zero. A write to one of them raises `wrErr` in the same cycle and changes nothing.
- R9: Indices 48 to 54 are write-only. A read of one of them raises `rdErr` and returns zero. A write to one of them raises no error. The write sets `sideStrobe` bit (index minus 48) high for exactly the one cycle after the write's clock edge.
- R10: Indices 55 to 63 are unassigned. A read raises `rdErr` and returns zero. A write raises `wrErr` and has no effect.
- R11: While `wrSpec` is high, a write changes no register, fires no strobe and raises no `wrErr`.
- R12: `rdErr` is only raised while `rdEn` is high. `wrErr` is only raised while `wrEn` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| cpuId | input | CPU_ID_W | Processor identifier, loaded into scratch index 16 at reset |
| rdEn | input | 1 | Read access valid (gates the read error) |
| rdIdx | input | 6 | Read index |
| rdData | output | 64 | Read data, combinational from `rdIdx` |
| rdErr | output | 1 | Illegal read (write-only or unassigned index) |
| wrEn | input | 1 | Write request |
| wrIdx | input | 6 | Write index |
| wrData | input | 64 | Write data |
| wrSpec | input | 1 | Write is mis-speculated and must be dropped |
| wrErr | output | 1 | Illegal write (read-only or unassigned index) |
| sideStrobe | output | 7 | One-cycle command strobes for write-only indices 48 to 54 |

## Verification
`rdData`, `rdErr` and `wrErr` are combinational, so they are due in the same cycle as the request. A stored write is first visible on a read in the next cycle. A command strobe is due exactly one cycle after its write. The cycle-count low half moves by one on every edge.

The bench changes its inputs on the falling edge and compares all four outputs 1 ns before the next rising edge. It then advances its behavioural model on that rising edge, so each expected value already includes every register update up to the cycle being checked.

// File: rtl/ctl_reg_pkg.sv
package ctl_reg_pkg;

  localparam int DATA_W  = 64;
  localparam int IDX_W   = 6;
  localparam int NUM_IDX = 1 << IDX_W;
  localparam int CNT_W   = 32;

  // index layout
  localparam int SCRATCH_ID   = 16;
  localparam int IDX_PAL_BASE = 24;
  localparam int IDX_MACH_CTL = 28;
  localparam int IDX_CYC      = 29;
  localparam int IDX_EXC_ADDR = 30;
  localparam int IDX_AST_REQ  = 31;
  localparam int IDX_AST_EN   = 32;
  localparam int IDX_I_MODE   = 33;
  localparam int IDX_D_MODE   = 34;
  localparam int IDX_I_CTL    = 35;
  localparam int IDX_I_PTBASE = 36;
  localparam int IDX_D_PTBASE = 37;
  localparam int IDX_DC_TEST  = 38;
  localparam int IDX_DC_MODE  = 39;
  localparam int IDX_MAF_MODE = 40;
  localparam int IDX_EXC_SUM  = 41;
  localparam int IDX_EXC_MASK = 42;
  localparam int RO_FIRST     = 43;
  localparam int RO_LAST      = 47;
  localparam int WO_FIRST     = 48;
  localparam int WO_LAST      = 54;
  localparam int STB_N        = WO_LAST - WO_FIRST + 1;

  localparam logic [DATA_W-1:0] MACH_CTL_RST = 64'h6;

  typedef enum logic [2:0] {
    K_FULL, K_MASK, K_CLEAR, K_RO, K_WO, K_NONE
  } kind_e;

  typedef struct packed {
    logic              wrStore;
    logic [IDX_W-1:0]  wrSel;
    logic [DATA_W-1:0] wrMask;
    logic [IDX_W-1:0]  rdSel;
    logic [STB_N-1:0]  sideFire;
  } strobe_t;

  function automatic kind_e regKind(input logic [IDX_W-1:0] idx);
    int i;
    i = int'(idx);
    if (i <= IDX_CYC)                         return K_FULL;
    else if (i <= IDX_MAF_MODE)               return K_MASK;
    else if (i <= IDX_EXC_MASK)               return K_CLEAR;
    else if (i <= RO_LAST)                    return K_RO;
    else if (i <= WO_LAST)                    return K_WO;
    else                                      return K_NONE;
  endfunction

  function automatic logic [DATA_W-1:0] regMask(input logic [IDX_W-1:0] idx);
    case (int'(idx))
      IDX_EXC_ADDR:               return ~64'h2;
      IDX_AST_REQ, IDX_AST_EN:    return 64'hF;
      IDX_I_MODE, IDX_D_MODE:     return 64'h18;
      IDX_I_CTL:                  return 64'hFF_FFFF_0300;
      IDX_I_PTBASE, IDX_D_PTBASE: return 64'hFFFF_FFFF_C000_0000;
      IDX_DC_TEST:                return 64'h1FFB;
      IDX_DC_MODE, IDX_MAF_MODE:  return 64'h3F;
      IDX_EXC_SUM, IDX_EXC_MASK:  return '0;
      default:                    return '1;
    endcase
  endfunction

endpackage

// File: rtl/ctl_reg_decode.sv
module ctl_reg_decode
  import ctl_reg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdEn,
  input  logic [IDX_W-1:0] rdIdx,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             wrSpec,
  output strobe_t          stb,
  output logic             rdErr,
  output logic             wrErr
);

  kind_e rdKind;
  kind_e wrKind;
  logic  wrLive;

  always_comb begin
    rdKind       = regKind(rdIdx);
    wrKind       = regKind(wrIdx);
    wrLive       = wrEn && !wrSpec;
    stb.rdSel    = rdIdx;
    stb.wrSel    = wrIdx;
    stb.wrMask   = regMask(wrIdx);
    stb.wrStore  = wrLive && (wrKind inside {K_FULL, K_MASK, K_CLEAR});
    stb.sideFire = '0;
    for (int s = 0; s < STB_N; s++) begin
      if (wrLive && int'(wrIdx) == WO_FIRST + s) stb.sideFire[s] = 1'b1;
    end
    rdErr = rdEn && (rdKind inside {K_WO, K_NONE});
    wrErr = wrLive && (wrKind inside {K_RO, K_NONE});
  end

  // R8
  err_blocks_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrErr |-> !stb.wrStore);

  // R9
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.sideFire));

  // R12
  rd_err_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> !rdErr);

endmodule

// File: rtl/ctl_reg_store.sv
module ctl_reg_store
  import ctl_reg_pkg::*;
#(
  parameter logic [DATA_W-1:0] PAL_BASE = 64'h4000,
  parameter int                CPU_ID_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CPU_ID_W-1:0] cpuId,
  input  strobe_t             stb,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output logic [STB_N-1:0]    sideStrobe
);

  localparam int HALF = DATA_W - CNT_W;

  logic [DATA_W-1:0] regVal [NUM_IDX];
  logic [DATA_W-1:0] wrVal;
  logic [CNT_W-1:0]  cycQ;

  assign wrVal = wrData & stb.wrMask;

  always_ff @(posedge clk) begin
    if (!rstN) cycQ <= '0;
    else       cycQ <= cycQ + 1'b1;
  end

  for (genvar g = 0; g < NUM_IDX; g++) begin : g_reg
    if (g == IDX_CYC) begin : g_cyc
      logic [HALF-1:0] hiQ;
      always_ff @(posedge clk) begin
        if (!rstN)                                      hiQ <= '0;
        else if (stb.wrStore && int'(stb.wrSel) == g)   hiQ <= wrVal[DATA_W-1:CNT_W];
      end
      assign regVal[g] = {hiQ, cycQ};
    end else if (g < RO_FIRST) begin : g_rw
      localparam logic [DATA_W-1:0] RST_CONST =
        (g == IDX_PAL_BASE) ? PAL_BASE :
        (g == IDX_MACH_CTL) ? MACH_CTL_RST : '0;
      logic [DATA_W-1:0] q;
      if (g == SCRATCH_ID) begin : g_id
        always_ff @(posedge clk) begin
          if (!rstN)                                    q <= {{(DATA_W-CPU_ID_W){1'b0}}, cpuId};
          else if (stb.wrStore && int'(stb.wrSel) == g) q <= wrVal;
        end
      end else begin : g_const
        always_ff @(posedge clk) begin
          if (!rstN)                                    q <= RST_CONST;
          else if (stb.wrStore && int'(stb.wrSel) == g) q <= wrVal;
        end
      end
      assign regVal[g] = q;
    end else begin : g_zero
      assign regVal[g] = '0;
    end
  end

  assign rdData = regVal[stb.rdSel];

  always_ff @(posedge clk) begin
    if (!rstN) sideStrobe <= '0;
    else       sideStrobe <= stb.sideFire;
  end

  // R3
  cyc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> cycQ == $past(cycQ) + 1'b1);

  // R4
  exc_addr_bit1_chk: assert property (@(posedge clk) disable iff (!rstN)
    regVal[IDX_EXC_ADDR][1] == 1'b0);

  // R5
  ast_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    regVal[IDX_AST_REQ][DATA_W-1:4] == '0 && regVal[IDX_AST_EN][DATA_W-1:4] == '0);

  // R7
  exc_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    regVal[IDX_EXC_SUM] == '0 && regVal[IDX_EXC_MASK] == '0);

endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import ctl_reg_pkg::*;
#(
  parameter logic [63:0] PAL_BASE = 64'h4000,
  parameter int          CPU_ID_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CPU_ID_W-1:0] cpuId,
  input  logic                rdEn,
  input  logic [5:0]          rdIdx,
  output logic [63:0]         rdData,
  output logic                rdErr,
  input  logic                wrEn,
  input  logic [5:0]          wrIdx,
  input  logic [63:0]         wrData,
  input  logic                wrSpec,
  output logic                wrErr,
  output logic [6:0]          sideStrobe
);

  strobe_t stb;

  ctl_reg_decode u_decode (
    .clk   (clk),
    .rstN  (rstN),
    .rdEn  (rdEn),
    .rdIdx (rdIdx),
    .wrEn  (wrEn),
    .wrIdx (wrIdx),
    .wrSpec(wrSpec),
    .stb   (stb),
    .rdErr (rdErr),
    .wrErr (wrErr)
  );

  ctl_reg_store #(
    .PAL_BASE(PAL_BASE),
    .CPU_ID_W(CPU_ID_W)
  ) u_store (
    .clk       (clk),
    .rstN      (rstN),
    .cpuId     (cpuId),
    .stb       (stb),
    .wrData    (wrData),
    .rdData    (rdData),
    .sideStrobe(sideStrobe)
  );

  // R11
  spec_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSpec) |=> sideStrobe == '0);

  // R11
  spec_no_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrSpec |-> !wrErr);

  // R9
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sideStrobe != '0) |-> $past(wrEn && !wrSpec));

endmodule

// File: tb/ctl_reg_bank_tb.sv
module ctl_reg_bank_tb;

  localparam logic [63:0] PAL = 64'h4000;
  localparam logic [7:0]  CPU = 8'h5A;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  cpuId = CPU;
  logic        rdEn = 1'b0;
  logic [5:0]  rdIdx = '0;
  logic [63:0] rdData;
  logic        rdErr;
  logic        wrEn = 1'b0;
  logic [5:0]  wrIdx = '0;
  logic [63:0] wrData = '0;
  logic        wrSpec = 1'b0;
  logic        wrErr;
  logic [6:0]  sideStrobe;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [63:0] m [64];
  logic [31:0] mc;
  logic [6:0]  expStb;

  always #2 clk = ~clk;

  ctl_reg_bank #(.PAL_BASE(PAL), .CPU_ID_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .cpuId(cpuId),
    .rdEn(rdEn), .rdIdx(rdIdx), .rdData(rdData), .rdErr(rdErr),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData), .wrSpec(wrSpec),
    .wrErr(wrErr), .sideStrobe(sideStrobe)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<=100000 cycles", cyc);
      summary();
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] expRd(input int i);
    if (i == 29)     return {m[29][63:32], mc};
    else if (i < 48) return m[i];
    else             return 64'h0;
  endfunction

  function automatic logic [63:0] keepBits(input int i);
    case (i)
      30:      return ~64'h2;
      31, 32:  return 64'hF;
      33, 34:  return 64'h18;
      35:      return 64'hFF_FFFF_0300;
      36, 37:  return 64'hFFFF_FFFF_C000_0000;
      38:      return 64'h1FFB;
      39, 40:  return 64'h3F;
      41, 42:  return 64'h0;
      default: return {64{1'b1}};
    endcase
  endfunction

  task automatic modelEdge();
    if (!rstN) begin
      for (int i = 0; i < 64; i++) m[i] = '0;
      m[24] = PAL;
      m[28] = 64'h6;
      m[16] = {56'h0, cpuId};
      mc = '0;
      expStb = '0;
    end else begin
      int w;
      w = int'(wrIdx);
      mc = mc + 1;
      expStb = '0;
      if (wrEn && !wrSpec) begin
        if (w <= 42)                 m[w] = wrData & keepBits(w);
        else if (w >= 48 && w <= 54) expStb[w-48] = 1'b1;
      end
    end
  endtask

  task automatic step(input logic re, input int ri, input logic we, input int wi,
                      input logic [63:0] wd, input logic sp, input string tag);
    logic ewe;
    rdEn = re; rdIdx = 6'(ri); wrEn = we; wrIdx = 6'(wi); wrData = wd; wrSpec = sp;
    #1;
    ewe = we && !sp && ((wi >= 43 && wi <= 47) || wi >= 55);
    chk(tag, "rdData", rdData, expRd(ri));
    chk(tag, "rdErr", {63'h0, rdErr}, {63'h0, re && ri >= 48});
    chk(tag, "wrErr", {63'h0, wrErr}, {63'h0, ewe});
    chk(tag, "sideStrobe", {57'h0, sideStrobe}, {57'h0, expStb});
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  task automatic wrRd(input int idx, input logic [63:0] val, input string tag);
    step(1'b1, idx, 1'b1, idx, val, 1'b0, tag);
    step(1'b1, idx, 1'b0, 0, 64'h0, 1'b0, tag);
  endtask

  initial begin
    repeat (3) begin
      @(posedge clk);
      modelEdge();
    end
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset values of every index, R3 counter, R9 and R10 read errors
    for (int i = 0; i < 64; i++) begin
      if (i == 29)      step(1'b1, i, 1'b0, 0, 64'h0, 1'b0, "R3");
      else if (i >= 55) step(1'b1, i, 1'b0, 0, 64'h0, 1'b0, "R10");
      else if (i >= 48) step(1'b1, i, 1'b0, 0, 64'h0, 1'b0, "R9");
      else              step(1'b1, i, 1'b0, 0, 64'h0, 1'b0, "R1");
    end

    // R2 full writes
    wrRd(3, 64'hA5A5_0F0F_F0F0_5A5A, "R2");
    wrRd(16, 64'h1234_5678_9ABC_DEF0, "R2");
    wrRd(24, {64{1'b1}}, "R2");
    wrRd(28, 64'h8000_0000_0000_0001, "R2");

    // R3 cycle register: upper half stored, lower half live
    wrRd(29, 64'hDEAD_BEEF_1234_5678, "R3");
    repeat (3) step(1'b1, 29, 1'b0, 0, 64'h0, 1'b0, "R3");

    // R4 exception address bit 1
    wrRd(30, {64{1'b1}}, "R4");
    wrRd(30, 64'h0000_0000_0000_0006, "R4");

    // R5 narrow masks
    for (int i = 31; i <= 34; i++) wrRd(i, {64{1'b1}}, "R5");

    // R6 remaining masks
    for (int i = 35; i <= 40; i++) wrRd(i, {64{1'b1}}, "R6");
    wrRd(36, 64'h1234_5678_9ABC_DEF0, "R6");

    // R7 write-to-clear
    wrRd(41, {64{1'b1}}, "R7");
    wrRd(42, 64'h5555_5555_5555_5555, "R7");

    // R8 read-only writes
    for (int i = 43; i <= 47; i++) wrRd(i, {64{1'b1}}, "R8");

    // R9 write-only command strobes
    for (int i = 48; i <= 54; i++) wrRd(i, 64'hFFFF, "R9");
    step(1'b1, 0, 1'b1, 50, 64'h1, 1'b0, "R9");
    step(1'b1, 0, 1'b1, 51, 64'h1, 1'b0, "R9");
    step(1'b1, 0, 1'b0, 0, 64'h0, 1'b0, "R9");

    // R10 unassigned indices
    wrRd(55, {64{1'b1}}, "R10");
    wrRd(63, {64{1'b1}}, "R10");

    // R11 mis-speculated writes
    step(1'b1, 5, 1'b1, 5, 64'hCAFE, 1'b1, "R11");
    step(1'b1, 5, 1'b1, 52, 64'h1, 1'b1, "R11");
    step(1'b1, 5, 1'b1, 43, 64'h1, 1'b1, "R11");
    step(1'b1, 5, 1'b0, 0, 64'h0, 1'b0, "R11");

    // R12 enables gate the error flags
    step(1'b0, 60, 1'b0, 60, 64'h1, 1'b0, "R12");
    step(1'b0, 49, 1'b0, 44, 64'h1, 1'b0, "R12");

    // R2 random mix over every index
    for (int n = 0; n < 3000; n++) begin
      step(1'($urandom), int'($urandom_range(63, 0)), 1'($urandom),
           int'($urandom_range(63, 0)), {$urandom, $urandom},
           ($urandom_range(7, 0) == 0), "R2");
    end

    summary();
  end

endmodule